// File: doc/BRIEF.md
# Per-Frame Sync Word Detector

This block watches a serial bit stream that has already been recovered to one bit per clock, qualified by a valid strobe. It hunts for a fixed sync word, deserializes the payload that follows into parallel words, and marks the first word of each frame. Cycles with the strobe low carry no data and do not advance anything.

A search is armed only by a valid 1 that follows a valid 0. The arming bit counts as the first bit of the candidate sync word. If the candidate does not match exactly, the detector goes back to hunting. Once matched, it stays locked for a programmed number of payload words and then drops lock on its own. Phase may drift between frames, so each frame is acquired again with no state kept from the frame before.

Top module: `fsd_frame_sync`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block enters the hunting state with `locked`, `word_valid` and `frame_start` at 0. The previous-bit memory is cleared to 0, so a valid 1 as the very first bit after reset arms a search.
- R2: While hunting, a search is armed only by a valid 1 whose preceding valid bit was 0 (or reset). A 1 that follows a 1 does not arm a search.
- R3: The arming bit and the next SYNC_W-1 valid bits are compared, first bit against bit SYNC_W-1 of `SYNC_WORD`. On an exact match `locked` is 1 from the clock edge that takes the last sync bit.
- R4: On any mismatch the block returns to hunting and produces no words. A new search then needs a fresh 0-to-1 transition.
- R5: Payload bits are packed MSB first, with the earliest bit in bit WORD_W-1 of `word_out`. `word_valid` is high for exactly one cycle, starting at the clock edge that takes the word's last bit.
- R6: `frame_start` is 1 together with `word_valid` for the first payload word of a frame, and 0 for every other word.
- R7: After FRAME_WORDS words, `locked` falls at the same edge that raises the last `word_valid`, and the block is hunting again. A following frame is acquired from scratch, even when only one 0 bit separates the two frames.
- R8: Cycles with `bit_valid` low are ignored: `bit_in` is not sampled, and no counter, window or state changes.
- R9: While a candidate is being compared or a frame is locked, 0-to-1 transitions do not restart a search. A sync-like pattern inside the payload is delivered as ordinary data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bit_in | input | 1 | Serial data bit |
| bit_valid | input | 1 | Qualifies `bit_in` for this cycle |
| word_out | output | WORD_W | Completed payload word, MSB first |
| word_valid | output | 1 | One-cycle strobe for `word_out` |
| frame_start | output | 1 | Marks the first payload word of a frame |
| locked | output | 1 | High while payload of a matched frame is being collected |

## Verification
A wrong internal state shows at the ports within one frame. A bad previous-bit memory or sync window either loses a frame that should lock, so its words never appear, or locks on a false pattern and emits words that should not exist. A miscounting bit or word counter shifts the packing, which appears in the next `word_out`, or moves the edge where `locked` falls by whole bits. A gap cycle that leaks into the logic corrupts the very next word. The bench therefore compares every emitted word and start flag, and checks the exact cycles where `locked` rises and falls.

// File: rtl/fsd_pkg.sv
// Shared types for the per-frame sync word detector.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package fsd_pkg;

    // Top-level control states: hunting for an arm, comparing a candidate,
    // collecting payload of a matched frame.
    typedef enum logic [1:0] {
        ST_SEARCH  = 2'd0,
        ST_CHECK   = 2'd1,
        ST_PAYLOAD = 2'd2
    } fsd_state_t;

endpackage

// File: rtl/fsd_edge_arm.sv
// Remembers the last valid bit and flags a valid 0-to-1 transition.
// Assumes: invalid cycles must leave the memory untouched; reset clears it to 0
// so a leading 1 after reset counts as a transition.
module fsd_edge_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_valid,
    output logic rise
);

    logic prev_q;

    // Track the most recent valid bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else if (bit_valid)
            prev_q <= bit_in;
    end

    assign rise = bit_valid & bit_in & ~prev_q;

    AST_RISE_NOT_TWICE: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise); // R2

endmodule

// File: rtl/fsd_sync_match.sv
// Keeps a window of recent valid bits and compares a candidate sync word.
// Assumes: 'start' pulses on the arming bit (first sync bit), 'active' is high
// while the remaining SYNC_W-1 bits arrive; SYNC_W >= 2.
module fsd_sync_match #(
    parameter int                 SYNC_W    = 16,
    parameter logic [SYNC_W-1:0]  SYNC_WORD = 16'hB38F
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_valid,
    input  logic start,
    input  logic active,
    output logic done,
    output logic ok
);

    localparam int CNT_W = $clog2(SYNC_W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(SYNC_W - 1);

    logic [SYNC_W-2:0] win_q;
    logic [SYNC_W-1:0] win_next;
    logic [CNT_W-1:0]  cnt_q;

    assign win_next = {win_q, bit_in};

    // Shift every valid bit into the history window.
    always_ff @(posedge clk) begin
        if (!rst_n)
            win_q <= '0;
        else if (bit_valid)
            win_q <= win_next[SYNC_W-2:0];
    end

    // Count sync bits received since the arming bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (start)
            cnt_q <= CNT_W'(1);
        else if (active && bit_valid)
            cnt_q <= cnt_q + 1'b1;
    end

    assign done = active & bit_valid & (cnt_q == LAST_IDX);
    assign ok   = (win_next == SYNC_WORD);

    AST_SYNC_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (cnt_q != '0) && (cnt_q < CNT_W'(SYNC_W))); // R3

    AST_SYNC_CNT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !bit_valid) |=> $stable(cnt_q)); // R8

endmodule

// File: rtl/fsd_deser.sv
// Packs locked payload bits into words, MSB first, and counts words per frame.
// Assumes: 'enable' is high only while a frame is locked and drops right after
// 'last_done'; WORD_W >= 2, FRAME_WORDS >= 1.
module fsd_deser #(
    parameter int WORD_W      = 8,
    parameter int FRAME_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_valid,
    input  logic              enable,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              frame_start,
    output logic              last_done
);

    localparam int BIT_CW  = $clog2(WORD_W + 1);
    localparam int WORD_CW = $clog2(FRAME_WORDS + 1);
    localparam logic [BIT_CW-1:0]  BIT_LAST  = BIT_CW'(WORD_W - 1);
    localparam logic [WORD_CW-1:0] WORD_LAST = WORD_CW'(FRAME_WORDS - 1);

    logic [WORD_W-2:0]  acc_q;
    logic [WORD_W-1:0]  acc_next;
    logic [BIT_CW-1:0]  bit_cnt_q;
    logic [WORD_CW-1:0] word_cnt_q;
    logic               take;
    logic               word_end;

    assign take      = enable & bit_valid;
    assign acc_next  = {acc_q, bit_in};
    assign word_end  = take & (bit_cnt_q == BIT_LAST);
    assign last_done = word_end & (word_cnt_q == WORD_LAST);

    // Shift accepted payload bits into the partial word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (take)
            acc_q <= acc_next[WORD_W-2:0];
    end

    // Bit and word position within the frame; cleared whenever not locked.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            bit_cnt_q  <= '0;
            word_cnt_q <= '0;
        end else if (take) begin
            if (word_end) begin
                bit_cnt_q  <= '0;
                word_cnt_q <= word_cnt_q + 1'b1;
            end else begin
                bit_cnt_q  <= bit_cnt_q + 1'b1;
            end
        end
    end

    // Register the completed word and its strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_out    <= '0;
            word_valid  <= 1'b0;
            frame_start <= 1'b0;
        end else begin
            word_valid  <= word_end;
            frame_start <= word_end && (word_cnt_q == '0);
            if (word_end)
                word_out <= acc_next;
        end
    end

    AST_START_WITH_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> word_valid); // R6

    AST_WORD_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> (word_cnt_q < WORD_CW'(FRAME_WORDS))); // R7

    AST_WORD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && WORD_W > 1) |=> !word_valid); // R5

endmodule

// File: rtl/fsd_frame_sync.sv
// Per-frame sync word detector: hunts for a 0-to-1 arm, compares SYNC_W bits
// against SYNC_WORD, then delivers FRAME_WORDS payload words and hunts again.
// Assumes: one recovered bit per clock qualified by bit_valid; each frame is
// preceded by at least one 0; nothing is carried from one frame to the next.
module fsd_frame_sync #(
    parameter int                SYNC_W      = 16,
    parameter logic [SYNC_W-1:0] SYNC_WORD   = 16'hB38F,
    parameter int                WORD_W      = 8,
    parameter int                FRAME_WORDS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_in,
    input  logic              bit_valid,
    output logic [WORD_W-1:0] word_out,
    output logic              word_valid,
    output logic              frame_start,
    output logic              locked
);

    import fsd_pkg::*;

    fsd_state_t state_q, state_d;
    logic       rise;
    logic       match_done;
    logic       match_ok;
    logic       frame_end;
    logic       arm;

    assign arm    = (state_q == ST_SEARCH) & rise;
    assign locked = (state_q == ST_PAYLOAD);

    fsd_edge_arm u_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .rise      (rise)
    );

    fsd_sync_match #(
        .SYNC_W    (SYNC_W),
        .SYNC_WORD (SYNC_WORD)
    ) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_in    (bit_in),
        .bit_valid (bit_valid),
        .start     (arm),
        .active    (state_q == ST_CHECK),
        .done      (match_done),
        .ok        (match_ok)
    );

    fsd_deser #(
        .WORD_W      (WORD_W),
        .FRAME_WORDS (FRAME_WORDS)
    ) u_deser (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_in      (bit_in),
        .bit_valid   (bit_valid),
        .enable      (locked),
        .word_out    (word_out),
        .word_valid  (word_valid),
        .frame_start (frame_start),
        .last_done   (frame_end)
    );

    // Next-state selection for hunt, compare and payload phases.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_SEARCH:  if (rise)       state_d = ST_CHECK;
            ST_CHECK:   if (match_done) state_d = match_ok ? ST_PAYLOAD : ST_SEARCH;
            ST_PAYLOAD: if (frame_end)  state_d = ST_SEARCH;
            default:                    state_d = ST_SEARCH;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_SEARCH;
        else
            state_q <= state_d;
    end

    AST_ARM_ON_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_CHECK && $past(state_q) == ST_SEARCH) |-> $past(bit_valid && bit_in)); // R2

    AST_LOCK_VIA_CHECK: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAYLOAD && $past(state_q) != ST_PAYLOAD) |-> $past(state_q) == ST_CHECK); // R3

    AST_GAP_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_valid |=> $stable(state_q)); // R8

    AST_WORD_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(state_q) == ST_PAYLOAD); // R5

    AST_UNLOCK_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> word_valid); // R7

endmodule

// File: tb/fsd_frame_sync_bench.sv
module fsd_frame_sync_bench;

    localparam int          SW   = 16;
    localparam logic [15:0] SYNC = 16'hB38F;
    localparam int          WW   = 8;
    localparam int          FW   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bit_in = 1'b0;
    logic          bit_valid = 1'b0;
    logic [WW-1:0] word_out;
    logic          word_valid;
    logic          frame_start;
    logic          locked;

    int checks = 0;
    int fails  = 0;
    bit gaps_on = 0;

    bit          stim_b[$];
    bit          stim_v[$];
    logic [WW:0] got_q[$];
    logic [WW:0] exp_q[$];

    always #4 clk = ~clk;

    fsd_frame_sync #(
        .SYNC_W(SW), .SYNC_WORD(SYNC), .WORD_W(WW), .FRAME_WORDS(FW)
    ) u_fsd_frame_sync (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_valid(bit_valid),
        .word_out(word_out), .word_valid(word_valid),
        .frame_start(frame_start), .locked(locked)
    );

    // Capture every delivered word with its start flag.
    always @(negedge clk)
        if (rst_n && word_valid) got_q.push_back({frame_start, word_out});

    task automatic check(bit cond, string req, string what, int act, int exp);
        checks++;
        if (!cond) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic send_bit(bit b, bit v);
        @(negedge clk);
        bit_in = b;
        bit_valid = v;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        bit_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        got_q.delete();
        stim_b.delete();
        stim_v.delete();
    endtask

    function automatic void add_bit(bit b);
        if (gaps_on && ($urandom % 4 == 0)) begin
            stim_b.push_back(1'($urandom % 2));
            stim_v.push_back(1'b0);
        end
        stim_b.push_back(b);
        stim_v.push_back(1'b1);
    endfunction

    function automatic void add_val(logic [31:0] val, int n);
        for (int k = n - 1; k >= 0; k--) add_bit(val[k]);
    endfunction

    // Reference: scan the valid bits as the requirements describe.
    function automatic void build_expected();
        bit vb[$];
        int i;
        bit prev;
        bit ok;
        logic [WW-1:0] w;
        exp_q.delete();
        foreach (stim_b[k]) if (stim_v[k]) vb.push_back(stim_b[k]);
        i = 0;
        prev = 1'b0;
        while (i < vb.size()) begin
            if (vb[i] && !prev) begin
                if (i + SW > vb.size()) break;
                ok = 1'b1;
                for (int k = 0; k < SW; k++) if (vb[i+k] != SYNC[SW-1-k]) ok = 1'b0;
                i += SW;
                prev = vb[i-1];
                if (ok) begin
                    for (int n = 0; n < FW; n++) begin
                        if (i + WW > vb.size()) begin
                            i = vb.size();
                            break;
                        end
                        for (int k = 0; k < WW; k++) w[WW-1-k] = vb[i+k];
                        exp_q.push_back({(n == 0), w});
                        i += WW;
                        prev = vb[i-1];
                    end
                end
            end else begin
                prev = vb[i];
                i++;
            end
        end
    endfunction

    task automatic run_and_compare(string req);
        build_expected();
        foreach (stim_b[k]) send_bit(stim_b[k], stim_v[k]);
        repeat (3) send_bit(1'b0, 1'b0);
        check(got_q.size() == exp_q.size(), req, "word count", got_q.size(), exp_q.size());
        if (got_q.size() == exp_q.size())
            foreach (got_q[k])
                check(got_q[k] === exp_q[k], req, "start+word", int'(got_q[k]), int'(exp_q[k]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(1234));
        do_reset();

        // R1: reset state
        check(locked == 1'b0 && word_valid == 1'b0 && frame_start == 1'b0, "R1",
              "reset outputs", {locked, word_valid, frame_start}, 0);

        // R3, R5, R6, R7: exact timing of one gap-free frame
        send_bit(1'b0, 1'b1);
        send_bit(1'b0, 1'b1);
        for (int k = SW - 1; k >= 1; k--) send_bit(SYNC[k], 1'b1);
        check(locked == 1'b0, "R3", "locked before last sync bit", locked, 0);
        send_bit(SYNC[0], 1'b1);
        check(locked == 1'b1, "R3", "locked after last sync bit", locked, 1);
        for (int k = 7; k >= 1; k--) send_bit(1'(8'hA5 >> k), 1'b1);
        check(word_valid == 1'b0, "R5", "no word before 8th bit", word_valid, 0);
        send_bit(1'b1, 1'b1);
        check(word_valid && frame_start && word_out == 8'hA5, "R5", "first word",
              int'(word_out), 8'hA5);
        check(frame_start == 1'b1, "R6", "start on first word", frame_start, 1);
        send_bit(1'b0, 1'b1);
        check(word_valid == 1'b0, "R5", "strobe one cycle", word_valid, 0);
        for (int k = 6; k >= 0; k--) send_bit(1'(8'h3C >> k), 1'b1);
        check(word_valid && !frame_start && word_out == 8'h3C, "R6", "second word no start",
              int'({frame_start, word_out}), 8'h3C);
        for (int k = 15; k >= 1; k--) send_bit(1'(16'h0FF1 >> k), 1'b1);
        check(locked == 1'b1, "R7", "still locked before last bit", locked, 1);
        send_bit(1'b1, 1'b1);
        check(locked == 1'b0 && word_valid && word_out == 8'hF1, "R7", "unlock with last word",
              int'({locked, word_out}), 8'hF1);

        // R1: a 1 as the first bit after reset arms
        do_reset();
        gaps_on = 0;
        add_val(SYNC, SW);
        add_val(32'h1234_5678, 32);
        add_val(0, 4);
        run_and_compare("R1");
        check(got_q.size() == FW, "R1", "words after leading 1", got_q.size(), FW);

        // R2, R4: arm one bit early -> mismatch, then a real frame re-arms
        do_reset();
        add_bit(1'b0);
        add_bit(1'b1);
        add_val(SYNC, SW);
        add_val(0, 40);
        add_val(SYNC, SW);
        add_val(32'hDEAD_BEEF, 32);
        add_val(0, 4);
        run_and_compare("R2");
        check(got_q.size() == FW, "R4", "only re-armed frame delivers", got_q.size(), FW);

        // R9: sync word hidden inside payload is plain data
        do_reset();
        add_bit(1'b0);
        add_val(SYNC, SW);
        add_val({8'h00, SYNC, 8'h00}, 32);
        add_val(0, 8);
        run_and_compare("R9");
        check(got_q.size() == FW, "R9", "no extra frame from payload", got_q.size(), FW);

        // R7: back-to-back frames separated by one 0
        do_reset();
        add_bit(1'b0);
        add_val(SYNC, SW);
        add_val(32'hCAFE_F00D, 32);
        add_bit(1'b0);
        add_val(SYNC, SW);
        add_val(32'h0102_0381, 32);
        add_val(0, 4);
        run_and_compare("R7");
        check(got_q.size() == 2 * FW, "R7", "two frames acquired", got_q.size(), 2 * FW);

        // R8: random invalid cycles with junk data change nothing
        do_reset();
        gaps_on = 1;
        add_bit(1'b0);
        add_val(SYNC, SW);
        add_val(32'h5AA5_C33C, 32);
        add_val(0, 4);
        run_and_compare("R8");
        check(got_q.size() == FW, "R8", "frame through gaps", got_q.size(), FW);

        // R3/R4/R5/R8: random frames, some with corrupted sync
        for (int it = 0; it < 150; it++) begin
            do_reset();
            gaps_on = 1'($urandom % 2);
            add_val(0, 1 + ($urandom % 3));
            for (int f = 0; f < 1 + int'($urandom % 3); f++) begin
                logic [15:0] s;
                s = SYNC;
                if ($urandom % 4 == 0) s[$urandom % 15] = ~s[$urandom % 15];
                add_val(s, SW);
                add_val($urandom, 32);
                add_val(0, 1 + ($urandom % 3));
            end
            add_val(0, 4);
            run_and_compare("R3/R4/R5/R8");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule